// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the serial clock of an I2C controller. It works from a high count and a low count given in input-clock cycles. One pair of counts serves standard speed and a second pair serves fast speed. A select input picks which pair is used.

When the controller is enabled, the block issues a start strobe and leaves the line released for the start hold time. After that it alternates between two phases. In the pulled-low phase, timing begins on the cycle the block pulls the line. In the released phase, timing begins only once the line is seen high again. If a target stretches the clock, the released phase therefore waits for it.

Each phase produces a one-cycle strobe. The data path uses one strobe to sample data at the rising edge and another to change data in the middle of the low phase.

The counts and the select are captured only while the block is disabled. Dropping the enable releases the line and clears the sequencer at once.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted or `enable` is 0, `scl_pull_low` is 0 and all three strobes are 0.
- R2: On the first cycle after `enable` is seen at 1, `start_stb` is high for exactly one cycle. The line then stays released for HCNT+3 cycles, counting that cycle, before the first pull.
- R3: Each pulled-low phase lasts exactly LCNT+1 cycles, counted from the first cycle of the pull.
- R4: Without stretching, each released phase between two pulls lasts HCNT+8 cycles. This is one cycle to see the line high, then HCNT+7 counted cycles.
- R5: If `scl_in` stays low for S cycles after the block releases the line, the released phase lasts S+HCNT+8 cycles. The high count starts only after `scl_in` is seen high.
- R6: With `fast_sel`=1 the fast pair (`fast_hcnt`, `fast_lcnt`) sets all timing. With `fast_sel`=0 the standard pair sets it.
- R7: Changes to the counts or to `fast_sel` while `enable` is 1 have no effect. Values held while `enable` is 0 take effect at the next enable.
- R8: `sample_stb` is high for exactly one cycle per released phase. Without stretching it falls on the second cycle of that phase; with stretch S it falls on cycle S+2.
- R9: `drive_stb` is high for exactly one cycle per low phase, at cycle index floor(LCNT/2) counted from 0.
- R10: One cycle after `enable` goes to 0, the line is released. A later enable restarts from the start strobe and a full start hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| fast_sel | input | 1 | 1 selects the fast count pair |
| std_hcnt | input | CNT_W | Standard-speed high count |
| std_lcnt | input | CNT_W | Standard-speed low count |
| fast_hcnt | input | CNT_W | Fast-speed high count |
| fast_lcnt | input | CNT_W | Fast-speed low count |
| scl_in | input | 1 | Synchronised level of the clock line |
| scl_pull_low | output | 1 | 1 requests the clock line driven low |
| start_stb | output | 1 | One-cycle strobe when the start hold begins |
| sample_stb | output | 1 | One-cycle strobe at the start of the high count |
| drive_stb | output | 1 | One-cycle strobe at the middle of the low phase |

## Verification
The bench builds the block with CNT_W=8, so every count fits in a few hundred cycles. With that width, a high count of 255 pushes the phase counter past 8 bits during the start hold and the high phase, which exercises the counter's extra bit. Counts of zero are also run, so the one-cycle low phase and a mid-low strobe at index 0 are checked. Both speed pairs are driven with distinct values, so a wrong pick changes the measured phase lengths.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    localparam int HOLD_EXTRA = 2;  // start hold spans hcnt+3 cycles
    localparam int HIGH_EXTRA = 6;  // counted high spans hcnt+7 cycles
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_hcnt,
    input  logic [CNT_W-1:0] std_lcnt,
    input  logic [CNT_W-1:0] fast_hcnt,
    input  logic [CNT_W-1:0] fast_lcnt,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] lcnt
);
    typedef struct packed {
        logic [CNT_W-1:0] hcnt;
        logic [CNT_W-1:0] lcnt;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.hcnt = fast_sel ? fast_hcnt : std_hcnt;
            cfg_d.lcnt = fast_sel ? fast_lcnt : std_lcnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign hcnt = cfg_q.hcnt;
    assign lcnt = cfg_q.lcnt;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(hcnt) && $stable(lcnt))); // R7
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    output logic             scl_pull_low,
    output logic             start_stb,
    output logic             sample_stb,
    output logic             drive_stb
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [CW-1:0] hold_last, high_last, low_last, mid_low;

    assign hold_last = {1'b0, hcnt} + CW'(HOLD_EXTRA);
    assign high_last = {1'b0, hcnt} + CW'(HIGH_EXTRA);
    assign low_last  = {1'b0, lcnt};
    assign mid_low   = {2'b00, lcnt[CNT_W-1:1]};

    always_comb begin
        seq_d     = seq_q;
        seq_d.cnt = seq_q.cnt + CW'(1);
        unique case (seq_q.ph)
            PH_IDLE: begin
                seq_d.cnt = '0;
                seq_d.ph  = PH_HOLD;
            end
            PH_HOLD: if (seq_q.cnt == hold_last) begin
                seq_d.ph  = PH_LOW;
                seq_d.cnt = '0;
            end
            PH_LOW: if (seq_q.cnt == low_last) begin
                seq_d.ph  = PH_WAIT;
                seq_d.cnt = '0;
            end
            PH_WAIT: begin
                seq_d.cnt = '0;
                if (scl_in) seq_d.ph = PH_HIGH;
            end
            PH_HIGH: if (seq_q.cnt == high_last) begin
                seq_d.ph  = PH_LOW;
                seq_d.cnt = '0;
            end
            default: begin
                seq_d.ph  = PH_IDLE;
                seq_d.cnt = '0;
            end
        endcase
        if (!enable) begin
            seq_d.ph  = PH_IDLE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign scl_pull_low = (seq_q.ph == PH_LOW);
    assign start_stb    = (seq_q.ph == PH_HOLD) && (seq_q.cnt == '0);
    assign sample_stb   = (seq_q.ph == PH_HIGH) && (seq_q.cnt == '0);
    assign drive_stb    = (seq_q.ph == PH_LOW)  && (seq_q.cnt == mid_low);

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull_low && !start_stb && !sample_stb && !drive_stb)); // R10
    AST_START_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> !scl_pull_low); // R2
    AST_STRETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_WAIT && !scl_in && enable) |=> (seq_q.ph == PH_WAIT && !sample_stb)); // R5
    AST_SAMPLE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_pull_low && $past(scl_in))); // R8
    AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> scl_pull_low); // R9
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stb, sample_stb, drive_stb})); // R8
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_hcnt,
    input  logic [CNT_W-1:0] std_lcnt,
    input  logic [CNT_W-1:0] fast_hcnt,
    input  logic [CNT_W-1:0] fast_lcnt,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             start_stb,
    output logic             sample_stb,
    output logic             drive_stb
);
    logic [CNT_W-1:0] act_hcnt, act_lcnt;

    scl_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fast_sel  (fast_sel),
        .std_hcnt  (std_hcnt),
        .std_lcnt  (std_lcnt),
        .fast_hcnt (fast_hcnt),
        .fast_lcnt (fast_lcnt),
        .hcnt      (act_hcnt),
        .lcnt      (act_lcnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .scl_in       (scl_in),
        .hcnt         (act_hcnt),
        .lcnt         (act_lcnt),
        .scl_pull_low (scl_pull_low),
        .start_stb    (start_stb),
        .sample_stb   (sample_stb),
        .drive_stb    (drive_stb)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk) !rst_n |-> !scl_pull_low); // R1
endmodule

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic fast_sel = 1'b0;
    logic [CNT_W-1:0] std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0, fast_lcnt = '0;
    logic stretch = 1'b0;
    logic scl_in;
    logic scl_pull_low, start_stb, sample_stb, drive_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int run_len, smp_pos, smp_num, drv_pos, drv_num, stt_num;

    always #2.5 clk = ~clk;

    assign scl_in = ~scl_pull_low & ~stretch;

    i2c_scl_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
        .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
        .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
        .scl_in(scl_in), .scl_pull_low(scl_pull_low),
        .start_stb(start_stb), .sample_stb(sample_stb), .drive_stb(drive_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedges while scl_pull_low stays at lvl; drops stretch at index s_n.
    task automatic measure_run(input logic lvl, input int s_n);
        run_len = 0; smp_pos = -1; smp_num = 0; drv_pos = -1; drv_num = 0; stt_num = 0;
        while (scl_pull_low == lvl && run_len < 1000) begin
            if (sample_stb) begin if (smp_pos < 0) smp_pos = run_len; smp_num++; end
            if (drive_stb)  begin if (drv_pos < 0) drv_pos = run_len; drv_num++; end
            if (start_stb)  stt_num++;
            if (run_len == s_n) stretch = 1'b0;
            run_len++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scl_pull_low && !start_stb && !sample_stb && !drive_stb, "R1 idle outputs",
            {scl_pull_low, start_stb, sample_stb, drive_stb}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!scl_pull_low && !start_stb && !sample_stb && !drive_stb, "R1 reset outputs",
            {scl_pull_low, start_stb, sample_stb, drive_stb}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_mode(input logic fs, input int h, input int l);
        go_idle();
        fast_sel = fs;
        if (fs) begin
            fast_hcnt = CNT_W'(h); fast_lcnt = CNT_W'(l);
            std_hcnt = CNT_W'(h + 9); std_lcnt = CNT_W'(l + 11);
        end else begin
            std_hcnt = CNT_W'(h); std_lcnt = CNT_W'(l);
            fast_hcnt = CNT_W'(h + 7); fast_lcnt = CNT_W'(l + 5);
        end
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(start_stb && !scl_pull_low, "R2 start strobe", start_stb, 1);
        measure_run(1'b0, -1);
        chk(run_len == h + 3, "R2 start hold length", run_len, h + 3);
        chk(stt_num == 1, "R2 start strobe count", stt_num, 1);
        measure_run(1'b1, -1);
        chk(run_len == l + 1, "R3 R6 low length", run_len, l + 1);
        chk(drv_num == 1 && drv_pos == l / 2, "R9 drive strobe position", drv_pos, l / 2);
        measure_run(1'b0, -1);
        chk(run_len == h + 8, "R4 R6 released length", run_len, h + 8);
        chk(smp_num == 1 && smp_pos == 1, "R8 sample strobe position", smp_pos, 1);
        measure_run(1'b1, -1);
        chk(run_len == l + 1, "R3 second low length", run_len, l + 1);
    endtask

    task automatic t_stretch(input int h, input int l, input int s);
        go_idle();
        fast_sel = 1'b0; std_hcnt = CNT_W'(h); std_lcnt = CNT_W'(l);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        measure_run(1'b0, -1);
        stretch = 1'b1;
        measure_run(1'b1, -1);
        chk(run_len == l + 1, "R3 low before stretch", run_len, l + 1);
        measure_run(1'b0, s);
        chk(run_len == s + h + 8, "R5 stretched released length", run_len, s + h + 8);
        chk(smp_num == 1 && smp_pos == s + 1, "R8 R5 sample after stretch", smp_pos, s + 1);
    endtask

    task automatic t_cfg_frozen();
        go_idle();
        fast_sel = 1'b0; std_hcnt = 8'd2; std_lcnt = 8'd2;
        fast_hcnt = 8'd20; fast_lcnt = 8'd20;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        std_hcnt = 8'd9; std_lcnt = 8'd9; fast_sel = 1'b1;
        measure_run(1'b0, -1);
        chk(run_len == 5, "R7 hold ignores live change", run_len, 5);
        measure_run(1'b1, -1);
        chk(run_len == 3, "R7 low ignores live change", run_len, 3);
        measure_run(1'b0, -1);
        chk(run_len == 10, "R7 released ignores live change", run_len, 10);
        go_idle();
        fast_sel = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        measure_run(1'b0, -1);
        chk(run_len == 12, "R7 new count after re-enable", run_len, 12);
        measure_run(1'b1, -1);
        chk(run_len == 10, "R7 new low after re-enable", run_len, 10);
    endtask

    task automatic t_disable_mid();
        go_idle();
        fast_sel = 1'b0; std_hcnt = 8'd1; std_lcnt = 8'd6;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        measure_run(1'b0, -1);
        @(negedge clk);
        chk(scl_pull_low, "R3 still low before drop", scl_pull_low, 1);
        enable = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!scl_pull_low && !drive_stb && !sample_stb, "R10 released after drop",
                scl_pull_low, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk(start_stb && !scl_pull_low, "R10 restart with start strobe", start_stb, 1);
        measure_run(1'b0, -1);
        chk(run_len == 4, "R10 full hold after restart", run_len, 4);
    endtask

    initial begin
        t_reset();
        t_mode(1'b0, 5, 7);
        t_mode(1'b1, 2, 5);
        t_mode(1'b0, 0, 0);
        t_mode(1'b1, 255, 3);
        t_stretch(3, 4, 5);
        t_cfg_frozen();
        t_disable_mid();
        go_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule